// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits next to a small processor core and decides, at each instruction boundary the core reports, whether an interrupt is taken and which one. It mixes two kinds of source. Latched sources record a rising edge in a flag. Level sources have no flag and request only while their input is high. A request counts only when its own enable bit and the global enable bit are both set. Among the requests that count, the one in the lowest vector slot wins.

When a request is accepted, the block raises a one-cycle accept strobe and presents the slot number and the vector address. The vector address is a table base plus two words per slot. The base is zero or a boot-region base, chosen by a select input. On acceptance, the global enable drops and the winner's flag is cleared. A return strobe from the core sets the global enable again. The first instruction boundary at or after a return never accepts, so one instruction of the interrupted program always runs first. Slot 0 is kept for reset and never issued. Source `i` occupies slot `i+1`.

Top module: `vec_irq_ctrl`

## Requirements
- R1: An accept (`take_o`=1) happens only when the winner's bit in `en_o` is 1 and `gie_o` is 1.
- R2: Source `i` uses slot `i+1`, and `slot_o` is never 0 on an accept. When several requests count, the lowest source index wins.
- R3: The cycle after an accept, `gie_o` is 0. A `gie_set_i` pulse sets it to 1 again.
- R4: The cycle after a `reti_i` pulse, `gie_o` is 1.
- R5: For a latched source, a rising edge on its `src_i` bit sets its `flag_o` bit whatever the enables are. The bit stays set until it is cleared.
- R6: A latched flag clears on the cycle after its source is accepted, or after a 1 is written to its bit of `flag_clr_i`. A rising edge in the same cycle as a clear leaves the flag set.
- R7: A level source (bits selected by `LEVEL_MASK`, by default bits 6 and 7) requests only while its input is high. It never sets a flag. If the input drops before the source is enabled, nothing is accepted.
- R8: The first `boundary_i` cycle at or after a `reti_i` pulse never accepts. This includes a boundary in the same cycle as the pulse. The boundary after that one may accept.
- R9: `vec_o` = base + 2 × `slot_o`. The base is 0 when `vsel_i`=0 and `BOOT_BASE` (default 0xC00) when `vsel_i`=1.
- R10: No accept happens in a cycle where `gie_clr_i` is 1, even if a request arrives in that cycle.
- R11: Accepts happen only in cycles with `boundary_i`=1, and at most one per boundary. Flags that gathered while global enable was off are then served one per accept, in priority order.
- R12: After reset, `gie_o`, `en_o`, `flag_o` and `take_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Source inputs, edge- or level-type per `LEVEL_MASK` |
| en_wr_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | N_SRC | New enable mask |
| flag_clr_i | input | N_SRC | Write-one-to-clear for latched flags |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable, effective in the same cycle |
| vsel_i | input | 1 | Vector base select: 0 selects zero, 1 selects `BOOT_BASE` |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Accept strobe |
| slot_o | output | SLOT_W | Slot of the current winner |
| vec_o | output | ADDR_W | Vector address of the current winner |
| gie_o | output | 1 | Global enable state |
| en_o | output | N_SRC | Enable mask |
| flag_o | output | N_SRC | Latched flags |

## Verification
Several controls can land on the same cycle as an accept decision. Two collisions are provoked on purpose. A global-disable strobe is driven together with a boundary while a level request is live. A return strobe is driven on a boundary while flags are pending. In both cases the bench checks that `take_o` stays low in that cycle, and it also checks `gie_o` in the next cycle. A third test drives a rising edge and a write-one-clear to the same flag at once, and checks that the flag stays set.

// File: rtl/irq_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes: slot 0 is reserved for reset; source i occupies slot i+1.
package irq_pkg;

    typedef enum logic {
        SRC_EDGE  = 1'b0,
        SRC_LEVEL = 1'b1
    } src_kind_e;

    // Kind of source i given a level mask
    function automatic src_kind_e kind_of(input int unsigned idx, input logic [63:0] lvl_mask);
        return lvl_mask[idx] ? SRC_LEVEL : SRC_EDGE;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
// Per-source request front end.
// Edge-type sources latch a flag on a rising input edge, regardless of enables.
// Level-type sources pass their input straight through and keep no flag.
// Assumes: ack_i is one-hot or zero and names the source being accepted.
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int unsigned N_SRC      = 8,
    parameter logic [63:0] LEVEL_MASK = 64'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] ack_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] raw_req_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (kind_of(g, LEVEL_MASK) == SRC_LEVEL) begin : g_level
            assign flag_o[g]    = 1'b0;
            assign raw_req_o[g] = src_i[g];
        end else begin : g_edge
            logic prev_q;
            logic flag_q;
            logic rise;

            assign rise = src_i[g] & ~prev_q;

            // Track previous input level for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= src_i[g];
            end

            // Flag: a new edge wins over hardware or software clear
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q <= 1'b0;
                else        flag_q <= rise | (flag_q & ~clr_i[g] & ~ack_i[g]);
            end

            assign flag_o[g]    = flag_q;
            assign raw_req_o[g] = flag_q;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
// Purely combinational; resolved anew every cycle.
module irq_prio_pick #(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N_SRC-1:0] onehot_o
);

    // Scan from the top down so the lowest index is written last
    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o    = IDX_W'(i);
                onehot_o = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irq_gie_ctl.sv
// Global enable and post-return gap tracking.
// Gap: the first boundary at or after a return strobe is blocked.
// Assumes: take_i is never high while block_o is high.
module irq_gie_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic reti_i,
    input  logic boundary_i,
    input  logic take_i,
    output logic gie_o,
    output logic block_o
);

    logic gie_q;
    logic gap_q;

    // Global enable: return sets, accept or disable clears, software set
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (reti_i) gie_q <= 1'b1;
        else if (take_i) gie_q <= 1'b0;
        else if (clr_i)  gie_q <= 1'b0;
        else if (set_i)  gie_q <= 1'b1;
    end

    // Gap pending: armed by a return away from a boundary, spent by a boundary
    always_ff @(posedge clk) begin
        if (!rst_n)          gap_q <= 1'b0;
        else if (boundary_i) gap_q <= 1'b0;
        else if (reti_i)     gap_q <= 1'b1;
    end

    assign gie_o   = gie_q;
    assign block_o = gap_q | reti_i;

endmodule

// File: rtl/irq_vec_gen.sv
// Vector address generation: base + SLOT_WORDS * (idx + 1).
// Assumes the base plus the largest offset fits in ADDR_W bits.
module irq_vec_gen #(
    parameter int unsigned N_SRC      = 8,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SLOT_WORDS = 2,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hC00,
    localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned SLOT_W = $clog2(N_SRC + 1)
) (
    input  logic              vsel_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [ADDR_W-1:0] vec_o
);

    logic [ADDR_W-1:0] base;

    // Slot number and address for the current winner
    always_comb begin
        base   = vsel_i ? BOOT_BASE : '0;
        slot_o = SLOT_W'(idx_i) + SLOT_W'(1);
        vec_o  = base + ADDR_W'(ADDR_W'(slot_o) * ADDR_W'(SLOT_WORDS));
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
// Top of the vectored priority interrupt controller.
// Combines the flag bank, enable mask, priority picker, global-enable
// control and vector generator. take_o is combinational so a same-cycle
// global disable or return blocks the accept at once.
// Assumes the core strobes boundary_i once per retired instruction.
module vec_irq_ctrl #(
    parameter int unsigned N_SRC      = 8,
    parameter logic [63:0] LEVEL_MASK = 64'hC0,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SLOT_WORDS = 2,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hC00,
    localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int unsigned SLOT_W = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              en_wr_i,
    input  logic [N_SRC-1:0]  en_wdata_i,
    input  logic [N_SRC-1:0]  flag_clr_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              vsel_i,
    input  logic              boundary_i,
    input  logic              reti_i,
    output logic              take_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic              gie_o,
    output logic [N_SRC-1:0]  en_o,
    output logic [N_SRC-1:0]  flag_o
);

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] raw_req;
    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] win_oh;
    logic [N_SRC-1:0] ack;
    logic [IDX_W-1:0] win_idx;
    logic             any_req;
    logic             gie;
    logic             block;
    logic             take;

    // Per-source enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_wdata_i;
    end

    irq_flag_bank #(
        .N_SRC      (N_SRC),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .clr_i     (flag_clr_i),
        .ack_i     (ack),
        .flag_o    (flag_o),
        .raw_req_o (raw_req)
    );

    assign req = raw_req & en_q;

    irq_prio_pick #(
        .N_SRC (N_SRC)
    ) u_pick (
        .req_i    (req),
        .any_o    (any_req),
        .idx_o    (win_idx),
        .onehot_o (win_oh)
    );

    irq_gie_ctl u_gie (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (gie_set_i),
        .clr_i      (gie_clr_i),
        .reti_i     (reti_i),
        .boundary_i (boundary_i),
        .take_i     (take),
        .gie_o      (gie),
        .block_o    (block)
    );

    irq_vec_gen #(
        .N_SRC      (N_SRC),
        .ADDR_W     (ADDR_W),
        .SLOT_WORDS (SLOT_WORDS),
        .BOOT_BASE  (BOOT_BASE)
    ) u_vec (
        .vsel_i (vsel_i),
        .idx_i  (win_idx),
        .slot_o (slot_o),
        .vec_o  (vec_o)
    );

    // Accept decision: boundary, global enable, no gap, no same-cycle disable
    always_comb begin
        take = boundary_i & gie & ~block & ~gie_clr_i & any_req;
        ack  = take ? win_oh : '0;
    end

    assign take_o = take;
    assign gie_o  = gie;
    assign en_o   = en_q;

endmodule

// File: rtl/irq_ctrl_chk.sv
// Property checker for vec_irq_ctrl, attached by bind below.
module irq_ctrl_chk #(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              reti_i,
    input logic              gie_clr_i,
    input logic              take_o,
    input logic              gie_o,
    input logic [SLOT_W-1:0] slot_o,
    input logic [N_SRC-1:0]  en_o
);

    logic en_hit;

    // Enable bit belonging to the reported slot
    always_comb begin
        en_hit = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (slot_o == SLOT_W'(i + 1)) en_hit = en_o[i];
        end
    end

    assert_take_gie_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> gie_o);

    assert_take_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> en_hit);

    assert_slot_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (slot_o != '0));

    assert_gie_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o);

    assert_reti_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> gie_o);

    assert_reti_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |-> !take_o);

    assert_cli_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_i |-> !take_o);

    assert_take_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> boundary_i);

endmodule

bind vec_irq_ctrl irq_ctrl_chk #(
    .N_SRC  (N_SRC),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .reti_i     (reti_i),
    .gie_clr_i  (gie_clr_i),
    .take_o     (take_o),
    .gie_o      (gie_o),
    .slot_o     (slot_o),
    .en_o       (en_o)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_i = '0;
    logic        en_wr_i = 1'b0;
    logic [7:0]  en_wdata_i = '0;
    logic [7:0]  flag_clr_i = '0;
    logic        gie_set_i = 1'b0;
    logic        gie_clr_i = 1'b0;
    logic        vsel_i = 1'b0;
    logic        boundary_i = 1'b0;
    logic        reti_i = 1'b0;
    logic        take_o;
    logic [3:0]  slot_o;
    logic [11:0] vec_o;
    logic        gie_o;
    logic [7:0]  en_o;
    logic [7:0]  flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .en_wr_i(en_wr_i),
        .en_wdata_i(en_wdata_i), .flag_clr_i(flag_clr_i), .gie_set_i(gie_set_i),
        .gie_clr_i(gie_clr_i), .vsel_i(vsel_i), .boundary_i(boundary_i),
        .reti_i(reti_i), .take_o(take_o), .slot_o(slot_o), .vec_o(vec_o),
        .gie_o(gie_o), .en_o(en_o), .flag_o(flag_o)
    );

    typedef struct packed {
        logic [7:0]  en;
        logic [7:0]  edges;
        logic [7:0]  lvl;
        logic        vsel;
        logic [3:0]  slot;   // 0 = no accept expected
        logic [11:0] vec;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{8'hFF, 8'h01, 8'h00, 1'b0, 4'd1, 12'h002},
        '{8'hFF, 8'h24, 8'h00, 1'b0, 4'd3, 12'h006},
        '{8'hFB, 8'h24, 8'h00, 1'b0, 4'd6, 12'h00C},
        '{8'hFF, 8'h00, 8'hC0, 1'b0, 4'd7, 12'h00E},
        '{8'hFF, 8'h20, 8'h40, 1'b1, 4'd6, 12'hC0C},
        '{8'h3F, 8'h00, 8'hC0, 1'b0, 4'd0, 12'h000},
        '{8'h00, 8'h3F, 8'h00, 1'b0, 4'd0, 12'h000},
        '{8'h80, 8'h01, 8'h80, 1'b0, 4'd8, 12'h010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R12: reset state
        tick(); tick();
        check("R12 gie", gie_o, 0);
        check("R12 en", en_o, 0);
        check("R12 flag", flag_o, 0);
        check("R12 take", take_o, 0);
        rst_n = 1'b1;
        tick();

        // Table: R1 R2 R7 R9 under several patterns
        for (int r = 0; r < 8; r++) begin
            en_wr_i = 1'b1; en_wdata_i = ROWS[r].en;
            src_i = ROWS[r].edges | ROWS[r].lvl; vsel_i = ROWS[r].vsel; gie_set_i = 1'b1;
            tick();
            en_wr_i = 1'b0; gie_set_i = 1'b0; src_i = ROWS[r].lvl; boundary_i = 1'b1;
            #1;
            check("R1/R2 take", take_o, ROWS[r].slot != 0);
            if (ROWS[r].slot != 0) begin
                check("R2 slot", slot_o, ROWS[r].slot);
                check("R9 vec", vec_o, ROWS[r].vec);
            end
            tick();
            boundary_i = 1'b0; src_i = '0; flag_clr_i = '1; gie_clr_i = 1'b1;
            tick();
            flag_clr_i = '0; gie_clr_i = 1'b0; vsel_i = 1'b0;
        end

        // R5: flag latched while disabled and held
        en_wr_i = 1'b1; en_wdata_i = 8'h00; src_i = 8'h08;
        tick();
        en_wr_i = 1'b0; src_i = '0;
        tick(); tick();
        check("R5 flag held", flag_o, 8'h08);
        en_wr_i = 1'b1; en_wdata_i = 8'h08; gie_set_i = 1'b1;
        tick();
        en_wr_i = 1'b0; gie_set_i = 1'b0; boundary_i = 1'b1;
        #1;
        check("R1 take src3", take_o, 1);
        check("R2 slot src3", slot_o, 4);
        tick();
        boundary_i = 1'b0;
        check("R6 hw clear", flag_o, 8'h00);
        check("R3 gie drop", gie_o, 0);

        // R6: write-one-to-clear, and edge wins over clear
        src_i = 8'h02;
        tick();
        src_i = '0;
        check("R6 flag set", flag_o, 8'h02);
        flag_clr_i = 8'h02;
        tick();
        flag_clr_i = '0;
        check("R6 w1c", flag_o, 8'h00);
        src_i = 8'h02; flag_clr_i = 8'h02;
        tick();
        src_i = '0; flag_clr_i = '0;
        check("R6 set wins", flag_o, 8'h02);
        flag_clr_i = 8'h02;
        tick();
        flag_clr_i = '0;

        // R7: level that drops before enable is lost; no flag kept
        en_wr_i = 1'b1; en_wdata_i = 8'h00; src_i = 8'h40;
        tick();
        en_wr_i = 1'b0; src_i = '0;
        check("R7 no flag", flag_o, 8'h00);
        tick();
        en_wr_i = 1'b1; en_wdata_i = 8'h40; gie_set_i = 1'b1;
        tick();
        en_wr_i = 1'b0; gie_set_i = 1'b0; boundary_i = 1'b1;
        #1;
        check("R7 dropped level", take_o, 0);
        tick();
        src_i = 8'h40;
        #1;
        check("R7 live level", take_o, 1);
        check("R7 slot", slot_o, 7);
        tick();
        boundary_i = 1'b0; src_i = '0;

        // R11/R8/R4: pending flags served in order, gap after return
        en_wr_i = 1'b1; en_wdata_i = 8'hFF; src_i = 8'h12;
        tick();
        en_wr_i = 1'b0; src_i = '0;
        tick();
        gie_set_i = 1'b1;
        tick();
        gie_set_i = 1'b0; boundary_i = 1'b1;
        #1;
        check("R11 first slot", slot_o, 2);
        check("R11 first take", take_o, 1);
        tick();
        #1;
        check("R3 no take gie off", take_o, 0);
        reti_i = 1'b1;
        #1;
        check("R8 reti boundary", take_o, 0);
        tick();
        reti_i = 1'b0;
        check("R4 gie set", gie_o, 1);
        #1;
        check("R11 second take", take_o, 1);
        check("R9 second vec", vec_o, 12'h00A);
        tick();
        boundary_i = 1'b0;

        // R8: lone return then two boundaries
        src_i = 8'h01;
        tick();
        src_i = '0; reti_i = 1'b1;
        tick();
        reti_i = 1'b0;
        check("R4 gie after reti", gie_o, 1);
        boundary_i = 1'b1;
        #1;
        check("R8 first boundary blocked", take_o, 0);
        tick();
        #1;
        check("R8 second boundary", take_o, 1);
        check("R8 slot", slot_o, 1);
        tick();
        boundary_i = 1'b0;

        // R10: disable and request on the same boundary
        gie_set_i = 1'b1;
        tick();
        gie_set_i = 1'b0; src_i = 8'h80; boundary_i = 1'b1; gie_clr_i = 1'b1;
        #1;
        check("R10 same-cycle disable", take_o, 0);
        tick();
        gie_clr_i = 1'b0; boundary_i = 1'b0;
        check("R10 gie off", gie_o, 0);
        #1;
        check("R1 gie off no take", take_o, 0);

        // R11: no boundary, no accept
        gie_set_i = 1'b1;
        tick();
        gie_set_i = 1'b0;
        #1;
        check("R11 no boundary", take_o, 0);
        tick();
        check("R11 gie kept", gie_o, 1);
        src_i = '0;
        tick();

        finish_run();
    end

endmodule